// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control core of a small 16-bit processor. It owns the program counter, the address register, the instruction register, an operand latch and an eight-entry, 16-bit register array. It walks a finite-state sequence that prepares the machine after reset, fetches instruction words from an external memory, and carries out six instruction kinds: load from memory, load immediate, store, register move, branch-if-equal and unconditional branch. The single compare for the conditional branch is the only arithmetic.

Memory traffic is one transfer at a time. The controller raises the valid strobe with the address, the write flag and, for writes, the data. The transfer completes on the rising clock edge where both the valid strobe and memory ready are high. While ready is low, back-pressure holds the controller in its access state, and every request output and the program counter stay frozen. Read data is taken only on the completing edge.

The current state code and the program counter are brought out for observation.

Top module: `mcpu_seq`

## Requirements
- R1: While `rst` is 1, the state code is 0, the program counter is 0 and the valid strobe is low.
- R2: After `rst` falls, the state code steps 0,1,2,3,4,5 on successive clock edges. In state 5 the controller requests a read of address 0 and stays in state 5 while ready is low.
- R3: When ready is high in state 5, the read word is taken as the instruction and the next state is 8, which is the decode/execute state.
- R4: A transfer completes only on an edge where the valid strobe and ready are both high. Until then, the valid strobe, address, write flag and program counter hold their values. The valid strobe is low in every state that does no transfer.
- R5: Instruction fetch reads the word at the program counter (states 6 then 7). The instruction word holds the opcode in bits 15:11, the destination register in bits 5:3 and the source register in bits 2:0. For every opcode except move, the second word at PC+1 carries an address, an immediate value or a branch target.
- R6: Opcode 1 (load) sets the destination register to mem[mem[PC+1]]. It passes through states 9,10,11,12,13,14 in that order, then returns to state 6 with PC+2.
- R7: Opcode 4 (load immediate) sets the destination register to mem[PC+1] and advances the PC by 2.
- R8: Opcode 2 (store) writes the source register to address mem[PC+1] with the write flag high and advances the PC by 2. The write flag is never high without the valid strobe.
- R9: Opcode 3 (move) copies the source register into the destination register and advances the PC by 1.
- R10: Opcode 5 compares the destination and source registers. When they are equal, the PC is loaded with the target word; when they differ, the PC advances by 2.
- R11: Opcode 6 always loads the PC with the target word.
- R12: Any other opcode changes no register, advances the PC by 1 and returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_ready_i | input | 1 | Memory ready; completes the current transfer |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_addr_o | output | 16 | Transfer address, driven from the address register |
| mem_vma_o | output | 1 | Valid strobe; a transfer is requested |
| mem_wr_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 16 | Write data (source register) |
| dbg_state_o | output | 5 | Current state code |
| dbg_pc_o | output | 16 | Program counter |

## Verification
A short program exercises every opcode. It includes a branch that is taken and skips a load, a branch that is not taken, an unknown opcode, and a final self-loop. The skipped load is detected because a later store writes back a register that must still be zero. The responder's ready latency cycles through 0, 1 and 2 wait cycles. This separates a design that honours back-pressure from one that takes data early, and it exposes a request that drifts while waiting. The program-counter trace at each decode distinguishes each PC update rule (PC+1, PC+2, target).

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  typedef enum logic [4:0] {
    S_RST1 = 5'd0,  S_RST2 = 5'd1,  S_RST3 = 5'd2,  S_RST4 = 5'd3,
    S_RST5 = 5'd4,  S_RST6 = 5'd5,  S_FET1 = 5'd6,  S_FET2 = 5'd7,
    S_EXEC = 5'd8,
    S_LD1  = 5'd9,  S_LD2  = 5'd10, S_LD3  = 5'd11, S_LD4  = 5'd12,
    S_LD5  = 5'd13, S_LD6  = 5'd14,
    S_LI1  = 5'd15, S_LI2  = 5'd16, S_LI3  = 5'd17,
    S_ST1  = 5'd18, S_ST2  = 5'd19, S_ST3  = 5'd20, S_ST4  = 5'd21,
    S_ST5  = 5'd22,
    S_MV1  = 5'd23,
    S_BR1  = 5'd24, S_BR2  = 5'd25, S_BR3  = 5'd26
  } state_e;

  localparam int unsigned OPW = 5;
  localparam logic [OPW-1:0] OP_LOAD  = 5'd1;
  localparam logic [OPW-1:0] OP_STORE = 5'd2;
  localparam logic [OPW-1:0] OP_MOVE  = 5'd3;
  localparam logic [OPW-1:0] OP_LDI   = 5'd4;
  localparam logic [OPW-1:0] OP_BEQ   = 5'd5;
  localparam logic [OPW-1:0] OP_BRA   = 5'd6;

  typedef enum logic [1:0] {AR_HOLD, AR_PC, AR_PC1, AR_OPR} ar_sel_e;
  typedef enum logic [2:0] {PC_HOLD, PC_ZERO, PC_INC1, PC_INC2, PC_TGT} pc_op_e;

  typedef struct packed {
    ar_sel_e ar_sel;
    logic    vma;
    logic    wr;
    logic    ir_ld;
    logic    opr_ld;
    logic    rf_we;
    logic    rf_from_opr;
    pc_op_e  pc_op;
  } ctl_t;

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or posedge rst) begin
      if (rst)
        regs[g] <= '0;
      else if (we && waddr == IW'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcpu_fsm.sv
module mcpu_fsm
  import mcpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           ready,
  input  logic [OPW-1:0] opcode,
  input  logic           eq,
  output state_e         state,
  output ctl_t           ctl
);

  state_e nxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= S_RST1;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_RST1: begin ctl.pc_op = PC_ZERO; nxt = S_RST2; end
      S_RST2: begin ctl.ar_sel = AR_PC; nxt = S_RST3; end
      S_RST3: nxt = S_RST4;
      S_RST4: nxt = S_RST5;
      S_RST5: nxt = S_RST6;
      S_RST6: begin
        ctl.vma = 1'b1; ctl.ir_ld = 1'b1;
        if (ready) nxt = S_EXEC;
      end
      S_FET1: begin ctl.ar_sel = AR_PC; nxt = S_FET2; end
      S_FET2: begin
        ctl.vma = 1'b1; ctl.ir_ld = 1'b1;
        if (ready) nxt = S_EXEC;
      end
      S_EXEC: begin
        case (opcode)
          OP_LOAD:        nxt = S_LD1;
          OP_LDI:         nxt = S_LI1;
          OP_STORE:       nxt = S_ST1;
          OP_MOVE:        nxt = S_MV1;
          OP_BEQ, OP_BRA: nxt = S_BR1;
          default: begin ctl.pc_op = PC_INC1; nxt = S_FET1; end
        endcase
      end
      S_LD1: begin ctl.ar_sel = AR_PC1; nxt = S_LD2; end
      S_LD2: begin
        ctl.vma = 1'b1; ctl.opr_ld = 1'b1;
        if (ready) nxt = S_LD3;
      end
      S_LD3: begin ctl.ar_sel = AR_OPR; nxt = S_LD4; end
      S_LD4: begin
        ctl.vma = 1'b1; ctl.opr_ld = 1'b1;
        if (ready) nxt = S_LD5;
      end
      S_LD5: begin ctl.rf_we = 1'b1; ctl.rf_from_opr = 1'b1; nxt = S_LD6; end
      S_LD6: begin ctl.pc_op = PC_INC2; nxt = S_FET1; end
      S_LI1: begin ctl.ar_sel = AR_PC1; nxt = S_LI2; end
      S_LI2: begin
        ctl.vma = 1'b1; ctl.opr_ld = 1'b1;
        if (ready) nxt = S_LI3;
      end
      S_LI3: begin
        ctl.rf_we = 1'b1; ctl.rf_from_opr = 1'b1; ctl.pc_op = PC_INC2;
        nxt = S_FET1;
      end
      S_ST1: begin ctl.ar_sel = AR_PC1; nxt = S_ST2; end
      S_ST2: begin
        ctl.vma = 1'b1; ctl.opr_ld = 1'b1;
        if (ready) nxt = S_ST3;
      end
      S_ST3: begin ctl.ar_sel = AR_OPR; nxt = S_ST4; end
      S_ST4: begin
        ctl.vma = 1'b1; ctl.wr = 1'b1;
        if (ready) nxt = S_ST5;
      end
      S_ST5: begin ctl.pc_op = PC_INC2; nxt = S_FET1; end
      S_MV1: begin ctl.rf_we = 1'b1; ctl.pc_op = PC_INC1; nxt = S_FET1; end
      S_BR1: begin ctl.ar_sel = AR_PC1; nxt = S_BR2; end
      S_BR2: begin
        ctl.vma = 1'b1; ctl.opr_ld = 1'b1;
        if (ready) nxt = S_BR3;
      end
      S_BR3: begin
        ctl.pc_op = (opcode == OP_BRA || eq) ? PC_TGT : PC_INC2;
        nxt = S_FET1;
      end
      default: nxt = S_RST1;
    endcase
  end

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
  import mcpu_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 16,
  parameter int unsigned NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_vma_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [4:0]    dbg_state_o,
  output logic [AW-1:0] dbg_pc_o
);

  localparam int unsigned IW = $clog2(NREG);

  state_e        state;
  ctl_t          ctl;
  logic [AW-1:0] pc, ar;
  logic [DW-1:0] ir, opr;
  logic [DW-1:0] rd_val, rs_val, wb_val;
  logic [IW-1:0] rd_idx, rs_idx;
  logic [OPW-1:0] opcode;
  logic          xfer;

  assign opcode = ir[DW-1 -: OPW];
  assign rd_idx = ir[2*IW-1:IW];
  assign rs_idx = ir[IW-1:0];
  assign xfer   = ctl.vma && mem_ready_i;

  mcpu_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .ready  (mem_ready_i),
    .opcode (opcode),
    .eq     (rd_val == rs_val),
    .state  (state),
    .ctl    (ctl)
  );

  assign wb_val = ctl.rf_from_opr ? opr : rs_val;

  mcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl.rf_we),
    .waddr   (rd_idx),
    .wdata   (wb_val),
    .raddr_a (rd_idx),
    .rdata_a (rd_val),
    .raddr_b (rs_idx),
    .rdata_b (rs_val)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      opr <= '0;
    end else begin
      case (ctl.pc_op)
        PC_ZERO: pc <= '0;
        PC_INC1: pc <= pc + AW'(1);
        PC_INC2: pc <= pc + AW'(2);
        PC_TGT:  pc <= AW'(opr);
        default: pc <= pc;
      endcase
      case (ctl.ar_sel)
        AR_PC:   ar <= pc;
        AR_PC1:  ar <= pc + AW'(1);
        AR_OPR:  ar <= AW'(opr);
        default: ar <= ar;
      endcase
      if (xfer && ctl.ir_ld)  ir  <= mem_rdata_i;
      if (xfer && ctl.opr_ld) opr <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = ar;
  assign mem_vma_o   = ctl.vma;
  assign mem_wr_o    = ctl.wr;
  assign mem_wdata_o = ctl.wr ? rs_val : '0;
  assign dbg_state_o = state;
  assign dbg_pc_o    = pc;

endmodule

// File: rtl/mcpu_seq_chk.sv
module mcpu_seq_chk
  import mcpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_vma_o,
  input logic          mem_wr_o,
  input logic [4:0]    dbg_state_o,
  input logic [AW-1:0] dbg_pc_o
);

  // R2
  rst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state_o == S_RST1) |=> (dbg_state_o == S_RST2));

  // R2
  rst_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state_o == S_RST6 && !mem_ready_i) |=> (dbg_state_o == S_RST6));

  // R3
  rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state_o == S_RST6 && mem_ready_i) |=> (dbg_state_o == S_EXEC));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_vma_o && !mem_ready_i) |=>
      (mem_vma_o && $stable(mem_addr_o) && $stable(mem_wr_o)));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_vma_o && !mem_ready_i) |=> $stable(dbg_pc_o));

  // R8
  wr_has_vma_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> mem_vma_o);

  // R6
  load_order_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state_o == S_LD5) |=> (dbg_state_o == S_LD6));

endmodule

bind mcpu_seq mcpu_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_vma_o   (mem_vma_o),
  .mem_wr_o    (mem_wr_o),
  .dbg_state_o (dbg_state_o),
  .dbg_pc_o    (dbg_pc_o)
);

// File: tb/mcpu_seq_tb.sv
module mcpu_seq_tb;

  localparam int S_FETCH1 = 6;
  localparam int S_DECODE = 8;
  localparam int S_LDFIRST = 9;
  localparam int S_LDLAST  = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ready = 1'b0;
  logic [15:0] rdata = '0;
  logic [15:0] addr, wdata, pc;
  logic        vma, wr;
  logic [4:0]  state;

  int n_chk = 0;
  int n_bad = 0;
  int nacc = 0;
  int wcnt = 0;
  int cycles = 0;
  bit timeout = 1'b0;
  logic [15:0] last_addr = '0;
  logic [4:0]  prev_state = '0;
  logic [15:0] mem [256];
  logic [31:0] exp_wr [$];
  logic [15:0] exp_pc [$];

  always #10 clk = ~clk;

  mcpu_seq u_dut (
    .clk         (clk),
    .rst         (rst),
    .mem_ready_i (ready),
    .mem_rdata_i (rdata),
    .mem_addr_o  (addr),
    .mem_vma_o   (vma),
    .mem_wr_o    (wr),
    .mem_wdata_o (wdata),
    .dbg_state_o (state),
    .dbg_pc_o    (pc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rd, input int rs);
    return 16'((op << 11) | (rd << 3) | rs);
  endfunction

  task automatic expect_write(input logic [15:0] a, input logic [15:0] d);
    exp_wr.push_back({a, d});
  endtask

  task automatic expect_pc(input logic [15:0] p);
    exp_pc.push_back(p);
  endtask

  // memory responder and write scoreboard monitor
  always @(negedge clk) begin
    if (rst || !vma) begin
      ready = 1'b0;
      wcnt = 0;
    end else if (!ready) begin
      if (wcnt > 0)
        check(addr == last_addr, "R4 address held while waiting", addr, last_addr);
      last_addr = addr;
      if (wcnt >= nacc % 3) begin
        ready = 1'b1;
        rdata = mem[addr[7:0]];
        if (wr) begin
          mem[addr[7:0]] = wdata;
          if (exp_wr.size() > 0) begin
            logic [31:0] e;
            e = exp_wr.pop_front();
            check({addr, wdata} == e, "R8 store address/data", {addr, wdata}, e);
          end else begin
            check(1'b0, "R8 unexpected write", {addr, wdata}, 0);
          end
        end
        nacc++;
      end else begin
        wcnt++;
      end
    end
  end

  // program-counter trace and load-sequence monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (state == S_DECODE && exp_pc.size() > 0) begin
        logic [15:0] e;
        e = exp_pc.pop_front();
        check(pc == e, "R5/R7/R9/R10/R11/R12 PC at decode", pc, e);
      end
      if (prev_state >= S_LDFIRST && prev_state < S_LDLAST && state != prev_state)
        check(state == prev_state + 1, "R6 load state order", state, prev_state + 1);
      if (prev_state == S_LDLAST)
        check(state == S_FETCH1, "R6 load returns to fetch", state, S_FETCH1);
      if (!vma && (state < 5))
        check(!wr, "R4 no write outside transfer", wr, 0);
    end
    prev_state = state;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) timeout = 1'b1;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = enc(4, 1, 0); mem[1]  = 16'h1234;
    mem[2]  = enc(4, 2, 0); mem[3]  = 16'h1234;
    mem[4]  = enc(3, 3, 1);
    mem[5]  = enc(5, 1, 2); mem[6]  = 16'd9;
    mem[7]  = enc(4, 4, 0); mem[8]  = 16'hDEAD;
    mem[9]  = enc(2, 0, 3); mem[10] = 16'h0080;
    mem[11] = enc(1, 5, 0); mem[12] = 16'h0090;
    mem[13] = enc(2, 0, 5); mem[14] = 16'h0081;
    mem[15] = enc(5, 1, 5); mem[16] = 16'd30;
    mem[17] = enc(31, 7, 7);
    mem[18] = enc(2, 0, 4); mem[19] = 16'h0082;
    mem[20] = enc(6, 0, 0); mem[21] = 16'd20;
    mem[16'h90] = 16'hBEEF;

    // R7, R9, R10 taken skip: r3 copy of r1
    expect_write(16'h0080, 16'h1234);
    // R6 load through pointer
    expect_write(16'h0081, 16'hBEEF);
    // R10 skipped load left r4 at zero
    expect_write(16'h0082, 16'h0000);
    foreach (mem[i]) if (0) ;
    expect_pc(0);  expect_pc(2);  expect_pc(4);  expect_pc(5);
    expect_pc(9);  expect_pc(11); expect_pc(13); expect_pc(15);
    expect_pc(17); expect_pc(18); expect_pc(20); expect_pc(20);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(state == 0, "R1 state in reset", state, 0);
    check(pc == 0, "R1 pc in reset", pc, 0);
    check(!vma, "R1 vma in reset", vma, 0);

    rst = 1'b0;
    check(state == 0, "R2 first reset step", state, 0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check(state == k, "R2 reset step order", state, k);
    end
    check(vma && addr == 0 && !wr, "R2 first fetch request at 0", addr, 0);
    while (state == 5 && !timeout) @(negedge clk);
    // R3 first instruction taken, decode entered
    check(state == S_DECODE, "R3 enter decode after first read", state, S_DECODE);

    wait ((exp_wr.size() == 0 && exp_pc.size() == 0) || timeout);
    repeat (20) @(negedge clk);
    // R11 unconditional branch self-loop keeps PC at 20
    check(pc == 20, "R11 branch self loop", pc, 20);
    check(mem[8'h82] == 16'h0000, "R10 skipped load not executed", mem[8'h82], 0);
    if (timeout) check(1'b0, "watchdog expired", cycles, 20000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule